// File: doc/BRIEF.md
# Flash Page Erase Sequencer with Verified Retry

This block runs the erase of a single flash page on behalf of a controller. A request names the page and picks one of two modes. In single mode the block issues one erase and reports completion without reading anything back. In retry mode it issues an erase at the weakest strength level and then asks an external comparator to verify the page. That comparator evaluates every bit of each flash word, including any ECC bits, and reports whether all of them read as one. In an ECC configuration the comparator has to use the compare-read-of-ones method. On a verify failure the block escalates to the next strength level and tries again. It stops when a verify passes or when the strongest level has also failed.

The flash array and the verify comparator sit outside the block. Each one is reached through a request line that stays high until a one-cycle completion pulse arrives. A 4-bit progress word records the current phase and attempt. This word is kept across a soft (system or brown-out) reset, so firmware can read where an interrupted erase stopped and decide how to resume. Only the hard reset clears it.

Top module: `erase_retry_seq`

## Requirements
- R1: After hard reset, busy, done, fail, erase_req and vfy_req are 0, erase_strength is 00 and progress is 0000.
- R2: When start is sampled high in single mode (retry_mode=0), erase_req rises on the next cycle with tgt_addr equal to the sampled page_addr and erase_strength 00. After erase_done the block pulses done with fail=0 and never raises vfy_req.
- R3: In retry mode the strength code is 00 on the first attempt, 01 on the second, 10 on the third and 11 on the fourth. Each erase_done is followed by vfy_req for the same tgt_addr, and a failed verify (vfy_valid=1, vfy_pass=0) starts the next attempt.
- R4: A passing verify (vfy_valid=1, vfy_pass=1) ends the operation with a done pulse and fail=0, and no further erase is issued.
- R5: A failed verify after the strength-11 attempt ends the operation with done and fail=1.
- R6: start is ignored while busy. retry_mode and page_addr are sampled only in the cycle start is accepted, so later changes to them have no effect on the running operation.
- R7: erase_done is ignored unless erase_req is high, and vfy_valid is ignored unless vfy_req is high.
- R8: The progress bit fields are as follows. Bit 3 means operating. Bit 2 means verify phase while operating, and fail once the operation has finished. Bits 1:0 hold the attempt number. While erasing, progress is {1,0,attempt}. While verifying, it is {1,1,attempt}. On completion it becomes {0,fail,attempt}.
- R9: A soft_rst pulse aborts any operation: busy, erase_req and vfy_req fall on the next cycle. progress keeps its value; only rst clears it.
- R10: done is a one-cycle pulse. fail keeps its value until the next accepted start. erase_req and vfy_req are never high together and are high only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard reset, synchronous, active high; clears everything |
| soft_rst | input | 1 | Soft reset, synchronous, active high; keeps progress |
| start | input | 1 | Request to begin an erase operation |
| retry_mode | input | 1 | 1 = verified retry mode, 0 = single erase |
| page_addr | input | ADDR_W | Page to erase, sampled at start |
| erase_done | input | 1 | One-cycle completion pulse from the array |
| vfy_valid | input | 1 | One-cycle verify result strobe |
| vfy_pass | input | 1 | Verify result: 1 = every bit read as one |
| erase_req | output | 1 | Erase request to the array, held until erase_done |
| erase_strength | output | STR_W | Erase strength code for the current attempt |
| vfy_req | output | 1 | Verify request, held until vfy_valid |
| tgt_addr | output | ADDR_W | Page address for the array and the comparator |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result of the last operation, 1 = not erased |
| progress | output | STR_W+2 | Resumable progress word |

## Verification
The bound checker watches on every cycle that the two request lines never overlap and are raised only while busy, and that done lasts a single cycle. It also confirms that the strength code and the target address hold steady during a request even when start is pulsed, that a verify request occurs only in the verify phase, that a fail result always comes with strength 11 and progress 0111, and that a soft reset leaves progress untouched. The bench scenarios show the rest: the ordered erase and verify stream for a pass on the first and third attempts and for exhaustion, the single-mode stream, rejection of stray handshake pulses in the wrong phase, and the progress word read out after an aborted operation.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ERASE  = 2'd1,
    ST_VERIFY = 2'd2
  } seq_state_t;

  // progress layout: {operating, phase_or_fail, attempt}
  localparam int PROG_FLAG_BITS = 2;

endpackage

// File: rtl/esq_attempt.sv
module esq_attempt #(
  parameter int STR_W = 2
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic             adv,
  output logic [STR_W-1:0] att,
  output logic [STR_W-1:0] att_nxt,
  output logic             is_last
);

  localparam logic [STR_W-1:0] LAST = {STR_W{1'b1}};
  localparam logic [STR_W-1:0] ONE  = {{(STR_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (load)     att_nxt = '0;
    else if (adv) att_nxt = att + ONE;
    else          att_nxt = att;
  end

  always_ff @(posedge clk) begin
    if (clr) att <= '0;
    else     att <= att_nxt;
  end

  assign is_last = (att == LAST);

endmodule

// File: rtl/esq_fsm.sv
module esq_fsm
  import erase_seq_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic       start,
  input  logic       retry_mode,
  input  logic       erase_done,
  input  logic       vfy_valid,
  input  logic       vfy_pass,
  input  logic       is_last,
  output seq_state_t nxt,
  output logic       latch,
  output logic       adv,
  output logic       go_verify,
  output logic       fin,
  output logic       fin_fail
);

  seq_state_t state;
  logic       retry_q;

  always_comb begin
    nxt       = state;
    latch     = 1'b0;
    adv       = 1'b0;
    go_verify = 1'b0;
    fin       = 1'b0;
    fin_fail  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          latch = 1'b1;
          nxt   = ST_ERASE;
        end
      end
      ST_ERASE: begin
        if (erase_done) begin
          if (retry_q) begin
            go_verify = 1'b1;
            nxt       = ST_VERIFY;
          end else begin
            fin = 1'b1;
            nxt = ST_IDLE;
          end
        end
      end
      ST_VERIFY: begin
        if (vfy_valid) begin
          if (vfy_pass) begin
            fin = 1'b1;
            nxt = ST_IDLE;
          end else if (is_last) begin
            fin      = 1'b1;
            fin_fail = 1'b1;
            nxt      = ST_IDLE;
          end else begin
            adv = 1'b1;
            nxt = ST_ERASE;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      state   <= ST_IDLE;
      retry_q <= 1'b0;
    end else begin
      state <= nxt;
      if (latch) retry_q <= retry_mode;
    end
  end

endmodule

// File: rtl/esq_progress.sv
module esq_progress #(
  parameter int STR_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_rst,
  input  logic               upd,
  input  logic               active,
  input  logic               phase_or_fail,
  input  logic [STR_W-1:0]   att_nxt,
  output logic [STR_W+1:0]   progress
);

  always_ff @(posedge clk) begin
    if (rst) begin
      progress <= '0;
    end else if (!soft_rst && upd) begin
      progress <= {active, phase_or_fail, att_nxt};
    end
  end

endmodule

// File: rtl/erase_retry_seq.sv
module erase_retry_seq
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int STR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              start,
  input  logic              retry_mode,
  input  logic [ADDR_W-1:0] page_addr,
  input  logic              erase_done,
  input  logic              vfy_valid,
  input  logic              vfy_pass,
  output logic              erase_req,
  output logic [STR_W-1:0]  erase_strength,
  output logic              vfy_req,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [STR_W+1:0]  progress
);

  localparam int PROG_W = STR_W + PROG_FLAG_BITS;

  logic             clr;
  seq_state_t       nxt;
  logic             latch, adv, go_verify, fin, fin_fail;
  logic             is_last;
  logic [STR_W-1:0] att_nxt;
  logic [PROG_W-1:0] prog_w;

  assign clr = rst | soft_rst;

  esq_fsm u_fsm (
    .clk        (clk),
    .clr        (clr),
    .start      (start),
    .retry_mode (retry_mode),
    .erase_done (erase_done),
    .vfy_valid  (vfy_valid),
    .vfy_pass   (vfy_pass),
    .is_last    (is_last),
    .nxt        (nxt),
    .latch      (latch),
    .adv        (adv),
    .go_verify  (go_verify),
    .fin        (fin),
    .fin_fail   (fin_fail)
  );

  esq_attempt #(.STR_W(STR_W)) u_att (
    .clk     (clk),
    .clr     (clr),
    .load    (latch),
    .adv     (adv),
    .att     (erase_strength),
    .att_nxt (att_nxt),
    .is_last (is_last)
  );

  esq_progress #(.STR_W(STR_W)) u_prog (
    .clk           (clk),
    .rst           (rst),
    .soft_rst      (soft_rst),
    .upd           (latch | adv | go_verify | fin),
    .active        (!fin),
    .phase_or_fail (fin ? fin_fail : go_verify),
    .att_nxt       (att_nxt),
    .progress      (prog_w)
  );

  assign progress = prog_w;

  always_ff @(posedge clk) begin
    if (clr) begin
      erase_req <= 1'b0;
      vfy_req   <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      tgt_addr  <= '0;
    end else begin
      erase_req <= (nxt == ST_ERASE);
      vfy_req   <= (nxt == ST_VERIFY);
      busy      <= (nxt != ST_IDLE);
      done      <= fin;
      if (latch)    fail <= 1'b0;
      else if (fin) fail <= fin_fail;
      if (latch) tgt_addr <= page_addr;
    end
  end

endmodule

// File: rtl/erase_retry_seq_chk.sv
module erase_retry_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int STR_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic              start,
  input logic              erase_done,
  input logic              vfy_valid,
  input logic              erase_req,
  input logic [STR_W-1:0]  erase_strength,
  input logic              vfy_req,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [STR_W+1:0]  progress
);

  a_r10_req_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(erase_req && vfy_req));

  a_r10_req_only_busy: assert property (@(posedge clk) disable iff (rst)
    (erase_req || vfy_req) |-> busy);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_fail_at_last: assert property (@(posedge clk) disable iff (rst)
    (done && fail) |-> (erase_strength == {STR_W{1'b1}} &&
                        progress == {2'b01, {STR_W{1'b1}}}));

  a_r3_strength_steady: assert property (@(posedge clk) disable iff (rst)
    erase_req |=> (!erase_req || $stable(erase_strength)));

  a_r2_verify_phase_only: assert property (@(posedge clk) disable iff (rst)
    vfy_req |-> (progress[STR_W+1:STR_W] == 2'b11));

  a_r4_pass_stops: assert property (@(posedge clk) disable iff (rst)
    (done && !fail && !start) |=> !erase_req);

  a_r6_addr_kept_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !soft_rst) |=> $stable(tgt_addr));

  a_r7_stray_vfy: assert property (@(posedge clk) disable iff (rst)
    (erase_req && !erase_done && !soft_rst) |=> erase_req);

  a_r9_soft_keeps_progress: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!busy && $stable(progress)));

endmodule

bind erase_retry_seq erase_retry_seq_chk #(.ADDR_W(ADDR_W), .STR_W(STR_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .soft_rst       (soft_rst),
  .start          (start),
  .erase_done     (erase_done),
  .vfy_valid      (vfy_valid),
  .erase_req      (erase_req),
  .erase_strength (erase_strength),
  .vfy_req        (vfy_req),
  .tgt_addr       (tgt_addr),
  .busy           (busy),
  .done           (done),
  .fail           (fail),
  .progress       (progress)
);

// File: tb/erase_retry_seq_tb_top.sv
module erase_retry_seq_tb_top;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          soft_rst = 1'b0;
  logic          start = 1'b0;
  logic          retry_mode = 1'b0;
  logic [AW-1:0] page_addr = '0;
  logic          erase_done = 1'b0;
  logic          vfy_valid = 1'b0;
  logic          vfy_pass = 1'b0;
  logic          erase_req, vfy_req, busy, done, fail;
  logic [1:0]    erase_strength;
  logic [AW-1:0] tgt_addr;
  logic [3:0]    progress;

  always #5 clk = ~clk;

  erase_retry_seq #(.ADDR_W(AW), .STR_W(2)) dut_i (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .start(start),
    .retry_mode(retry_mode), .page_addr(page_addr),
    .erase_done(erase_done), .vfy_valid(vfy_valid), .vfy_pass(vfy_pass),
    .erase_req(erase_req), .erase_strength(erase_strength),
    .vfy_req(vfy_req), .tgt_addr(tgt_addr), .busy(busy), .done(done),
    .fail(fail), .progress(progress)
  );

  typedef enum int {K_ERASE, K_VFY, K_DONE} kind_t;
  typedef struct {
    kind_t         kind;
    logic [AW-1:0] addr;
    logic [1:0]    str;
    logic          fl;
    logic [3:0]    prog;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   pass_at = 0;
  int   vcnt = 0;
  bit   auto_en = 1'b1;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input kind_t k, input logic [AW-1:0] a, input logic [1:0] s,
                      input logic f, input logic [3:0] p);
    exp_t e;
    e.kind = k; e.addr = a; e.str = s; e.fl = f; e.prog = p;
    q.push_back(e);
  endtask

  task automatic observe(input kind_t k);
    exp_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R3 unexpected event", k, -1);
      return;
    end
    e = q.pop_front();
    chk(e.kind == k, "R3 event order", k, e.kind);
    if (k == K_ERASE) begin
      chk(tgt_addr == e.addr, "R2 erase address", tgt_addr, e.addr);
      chk(erase_strength == e.str, "R3 strength code", erase_strength, e.str);
    end else if (k == K_VFY) begin
      chk(tgt_addr == e.addr, "R3 verify address", tgt_addr, e.addr);
    end else begin
      chk(fail == e.fl, "R4 R5 fail result", fail, e.fl);
      chk(progress == e.prog, "R8 final progress", progress, e.prog);
    end
  endtask

  // monitor: pops expected items as the design raises requests / done
  initial begin
    logic pe, pv;
    pe = 1'b0; pv = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (erase_req && !pe) observe(K_ERASE);
        if (vfy_req && !pv)   observe(K_VFY);
        if (done)             observe(K_DONE);
      end
      pe = erase_req; pv = vfy_req;
    end
  end

  // array model
  initial forever begin
    @(negedge clk);
    if (auto_en && erase_req) begin
      repeat (2) @(negedge clk);
      erase_done = 1'b1;
      @(negedge clk);
      erase_done = 1'b0;
    end
  end

  // verify comparator model
  initial forever begin
    @(negedge clk);
    if (auto_en && vfy_req) begin
      @(negedge clk);
      vfy_valid = 1'b1;
      vfy_pass  = (vcnt == pass_at);
      vcnt++;
      @(negedge clk);
      vfy_valid = 1'b0;
      vfy_pass  = 1'b0;
    end
  end

  task automatic do_start(input logic m, input logic [AW-1:0] a);
    @(negedge clk);
    vcnt = 0;
    retry_mode = m; page_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ed();
    erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
  endtask

  task automatic pulse_vf(input logic p);
    vfy_valid = 1'b1; vfy_pass = p; @(negedge clk);
    vfy_valid = 1'b0; vfy_pass = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !fail, "R1 status after reset", {busy, done, fail}, 0);
    chk(!erase_req && !vfy_req, "R1 requests after reset", {erase_req, vfy_req}, 0);
    chk(progress == 4'h0 && erase_strength == 2'b00, "R1 progress after reset", progress, 0);

    // R2 single mode
    push(K_ERASE, 24'h00A100, 2'b00, 1'b0, 4'h0);
    push(K_DONE,  24'h0, 2'b00, 1'b0, 4'b0000);
    do_start(1'b0, 24'h00A100);
    chk(busy && erase_req, "R2 erase raised after start", {busy, erase_req}, 3);
    wait_done();

    // R4 pass on first attempt
    pass_at = 0;
    push(K_ERASE, 24'h00B200, 2'b00, 1'b0, 4'h0);
    push(K_VFY,   24'h00B200, 2'b00, 1'b0, 4'h0);
    push(K_DONE,  24'h0, 2'b00, 1'b0, 4'b0000);
    do_start(1'b1, 24'h00B200);
    wait_done();
    repeat (4) @(negedge clk);
    chk(!erase_req && !busy, "R4 no erase after pass", erase_req, 0);

    // R3 pass on third attempt
    pass_at = 2;
    for (int i = 0; i < 3; i++) begin
      push(K_ERASE, 24'h00C300, 2'(i), 1'b0, 4'h0);
      push(K_VFY,   24'h00C300, 2'(i), 1'b0, 4'h0);
    end
    push(K_DONE, 24'h0, 2'b00, 1'b0, 4'b0010);
    do_start(1'b1, 24'h00C300);
    wait_done();

    // R5 exhaustion, R10 fail held
    pass_at = 9;
    for (int i = 0; i < 4; i++) begin
      push(K_ERASE, 24'h00D400, 2'(i), 1'b0, 4'h0);
      push(K_VFY,   24'h00D400, 2'(i), 1'b0, 4'h0);
    end
    push(K_DONE, 24'h0, 2'b00, 1'b1, 4'b0111);
    do_start(1'b1, 24'h00D400);
    wait_done();
    repeat (5) @(negedge clk);
    chk(fail && !done, "R10 fail held, done one cycle", {fail, done}, 2);

    // R6 start and inputs ignored while busy
    pass_at = 1;
    push(K_ERASE, 24'h00E500, 2'b00, 1'b0, 4'h0);
    push(K_VFY,   24'h00E500, 2'b00, 1'b0, 4'h0);
    push(K_ERASE, 24'h00E500, 2'b01, 1'b0, 4'h0);
    push(K_VFY,   24'h00E500, 2'b01, 1'b0, 4'h0);
    push(K_DONE,  24'h0, 2'b00, 1'b0, 4'b0001);
    do_start(1'b1, 24'h00E500);
    chk(!fail, "R10 fail cleared by new start", fail, 0);
    retry_mode = 1'b0; page_addr = 24'h0FFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(tgt_addr == 24'h00E500, "R6 address kept while busy", tgt_addr, 24'h00E500);
    wait_done();
    repeat (4) @(negedge clk);

    // R7 stray handshakes, R8 progress mid-operation
    auto_en = 1'b0;
    push(K_ERASE, 24'h00F600, 2'b00, 1'b0, 4'h0);
    push(K_VFY,   24'h00F600, 2'b00, 1'b0, 4'h0);
    push(K_ERASE, 24'h00F600, 2'b01, 1'b0, 4'h0);
    push(K_VFY,   24'h00F600, 2'b01, 1'b0, 4'h0);
    push(K_DONE,  24'h0, 2'b00, 1'b0, 4'b0001);
    do_start(1'b1, 24'h00F600);
    chk(progress == 4'b1000, "R8 progress while erasing", progress, 4'b1000);
    pulse_vf(1'b1);
    chk(erase_req && !vfy_req && busy, "R7 vfy_valid ignored while erasing", {erase_req, vfy_req}, 2);
    pulse_ed();
    chk(vfy_req && progress == 4'b1100, "R8 progress while verifying", progress, 4'b1100);
    pulse_ed();
    chk(!erase_req && vfy_req, "R7 erase_done ignored while verifying", {erase_req, vfy_req}, 1);
    pulse_vf(1'b0);
    chk(erase_req && erase_strength == 2'b01 && progress == 4'b1001,
        "R8 progress on second attempt", progress, 4'b1001);
    pulse_ed();
    pulse_vf(1'b1);
    chk(done && !fail, "R4 pass reported", {done, fail}, 2);
    @(negedge clk);
    auto_en = 1'b1;

    // R9 soft reset keeps progress
    pass_at = 9;
    for (int i = 0; i < 3; i++) begin
      push(K_ERASE, 24'h001700, 2'(i), 1'b0, 4'h0);
      if (i < 2) push(K_VFY, 24'h001700, 2'(i), 1'b0, 4'h0);
    end
    do_start(1'b1, 24'h001700);
    while (!(erase_req && erase_strength == 2'b10)) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(!busy && !erase_req && !vfy_req, "R9 soft reset aborts", {busy, erase_req, vfy_req}, 0);
    chk(progress == 4'b1010, "R9 progress kept over soft reset", progress, 4'b1010);
    repeat (6) @(negedge clk);
    chk(!busy && progress == 4'b1010, "R7 R9 late erase_done ignored when idle", progress, 4'b1010);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(progress == 4'h0, "R9 hard reset clears progress", progress, 0);
    chk(q.size() == 0, "R3 all expected events seen", q.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule